// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block holds the HI/LO register pair of a 32-bit load/store core and the arithmetic that fills it. A requester presents a 6-bit function code, two operand values (the values of the instruction's rs and rt registers) and a destination register index, then pulses `start`. Multiplies finish in one cycle and write the 64-bit product into the pair. Divides run on a sequential restoring engine of one quotient bit per cycle. The remainder goes to HI and the quotient goes to LO. Move-to operations load HI or LO from the rs value. Move-from operations return HI or LO, together with a write enable, for the core to put into its register file.

Every request ends with a one-cycle `done` pulse. While a divide runs, `busy` is high. The unit holds one request that arrives during that time and runs it in the cycle after the divide ends. A move-from issued behind a divide therefore returns the divide's result. While a request is held, the requester waits for its `done` before it sends another.

Top module: `hilo_muldiv`

## Requirements
- R1: Function 0x10 returns HI and function 0x12 returns LO on `wr_data`, with `wr_dest` equal to the request's destination index. `wr_en` and `done` are high for the one cycle after the clock edge that accepts the request.
- R2: Function 0x11 copies rs into HI and function 0x13 copies rs into LO. Each gives a `done` pulse with `wr_en` low. HI and LO change only when a request is accepted or a divide ends.
- R3: Function 0x18 forms the signed 64-bit product of rs and rt in one cycle. The upper half goes to HI and the lower half to LO.
- R4: Function 0x19 forms the unsigned 64-bit product of rs and rt in one cycle. The upper half goes to HI and the lower half to LO.
- R5: A move-from whose destination index is 0 still pulses `done` but never raises `wr_en`.
- R6: Function 0x1a divides rs by rt as signed values. The quotient, truncated toward zero, goes to LO. The remainder, which takes the dividend's sign, goes to HI. 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R7: Function 0x1b divides rs by rt as unsigned values, remainder to HI and quotient to LO. Each divide, signed or unsigned, holds `busy` high for exactly 32 cycles, and `done` is high in the cycle `busy` falls.
- R8: A divisor of zero, signed or unsigned, sets LO to 0xFFFFFFFF and HI to the unmodified dividend. No other signal is raised.
- R9: A request that arrives while `busy` is high is held and runs in the cycle after the divide completes. A held move-from returns the value the divide just wrote.
- R10: Any other function code pulses `done`, leaves HI and LO unchanged and does not raise `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| funct | input | 6 | Function code of the request |
| rs_val | input | 32 | First operand (dividend, multiplicand, move-to source) |
| rt_val | input | 32 | Second operand (divisor, multiplier) |
| dest | input | 5 | Destination register index for move-from |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register write enable for move-from results |
| wr_dest | output | 5 | Register index that goes with `wr_en` |
| wr_data | output | 32 | Value returned by move-from |

## Verification
The hardest case to reach from the ports is a move-from that arrives during a divide. Its result depends on the held request running only after the divider's final write to HI and LO. The bench drives that request on the cycle right after a divide starts and expects two `done` pulses on back-to-back cycles: the first with no write, the second carrying the remainder. Random operands are biased toward zero, all-ones and the most negative value, so the sign-fix and zero-divisor paths are hit often. This includes the overflowing signed quotient.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   funct,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  input  logic [4:0]   dest,
  output logic         busy,
  output logic         done,
  output logic         wr_en,
  output logic [4:0]   wr_dest,
  output logic [W-1:0] wr_data
);
  localparam int CW = $clog2(W);
  localparam logic [5:0] F_MFHI  = 6'h10;
  localparam logic [5:0] F_MTHI  = 6'h11;
  localparam logic [5:0] F_MFLO  = 6'h12;
  localparam logic [5:0] F_MTLO  = 6'h13;
  localparam logic [5:0] F_MULT  = 6'h18;
  localparam logic [5:0] F_MULTU = 6'h19;
  localparam logic [5:0] F_DIV   = 6'h1a;
  localparam logic [5:0] F_DIVU  = 6'h1b;

  logic [W-1:0] hi_q, lo_q;
  logic         pend_v;
  logic [5:0]   pend_f;
  logic [W-1:0] pend_a, pend_b;
  logic [4:0]   pend_d;
  logic [CW-1:0] cnt;
  logic [W-1:0] rem_q, quo_q, dvsr_q, dvnd_q;
  logic         negq_q, negr_q, zdiv_q;

  wire          take = !busy && (start || pend_v);
  wire [5:0]    f    = pend_v ? pend_f : funct;
  wire [W-1:0]  a    = pend_v ? pend_a : rs_val;
  wire [W-1:0]  b    = pend_v ? pend_b : rt_val;
  wire [4:0]    d    = pend_v ? pend_d : dest;

  wire          sgn_mul = (f == F_MULT);
  wire [2*W-1:0] prod = {{W{sgn_mul & a[W-1]}}, a} * {{W{sgn_mul & b[W-1]}}, b};

  wire          sgn_div = (f == F_DIV);
  wire          a_neg   = sgn_div & a[W-1];
  wire          b_neg   = sgn_div & b[W-1];
  wire [W-1:0]  a_mag   = a_neg ? -a : a;
  wire [W-1:0]  b_mag   = b_neg ? -b : b;

  wire [W:0]    rem_sh = {rem_q, quo_q[W-1]};
  wire [W:0]    trial  = rem_sh - {1'b0, dvsr_q};
  wire [W-1:0]  rem_nx = trial[W] ? rem_sh[W-1:0] : trial[W-1:0];
  wire [W-1:0]  quo_nx = {quo_q[W-2:0], ~trial[W]};
  wire          last   = busy && (cnt == CW'(W-1));
  wire [W-1:0]  q_fin  = zdiv_q ? '1 : (negq_q ? -quo_nx : quo_nx);
  wire [W-1:0]  r_fin  = zdiv_q ? dvnd_q : (negr_q ? -rem_nx : rem_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0;
      busy <= 1'b0; done <= 1'b0; wr_en <= 1'b0;
      wr_dest <= '0; wr_data <= '0;
      pend_v <= 1'b0; pend_f <= '0; pend_a <= '0; pend_b <= '0; pend_d <= '0;
      cnt <= '0; rem_q <= '0; quo_q <= '0; dvsr_q <= '0; dvnd_q <= '0;
      negq_q <= 1'b0; negr_q <= 1'b0; zdiv_q <= 1'b0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (start && busy && !pend_v) begin
        pend_v <= 1'b1;
        pend_f <= funct;
        pend_a <= rs_val;
        pend_b <= rt_val;
        pend_d <= dest;
      end
      if (take) begin
        pend_v <= 1'b0;
        unique case (f)
          F_MFHI, F_MFLO: begin
            done    <= 1'b1;
            wr_en   <= (d != 5'd0);
            wr_dest <= d;
            wr_data <= (f == F_MFHI) ? hi_q : lo_q;
          end
          F_MTHI: begin hi_q <= a; done <= 1'b1; end
          F_MTLO: begin lo_q <= a; done <= 1'b1; end
          F_MULT, F_MULTU: begin
            hi_q <= prod[2*W-1:W];
            lo_q <= prod[W-1:0];
            done <= 1'b1;
          end
          F_DIV, F_DIVU: begin
            busy   <= 1'b1;
            cnt    <= '0;
            rem_q  <= '0;
            quo_q  <= a_mag;
            dvsr_q <= b_mag;
            dvnd_q <= a;
            negq_q <= a_neg ^ b_neg;
            negr_q <= a_neg;
            zdiv_q <= (b == '0);
          end
          default: done <= 1'b1;
        endcase
      end else if (busy) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          hi_q <= r_fin;
          lo_q <= q_fin;
        end
      end
    end
  end

  logic [CW:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;
  end

  a_r5_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_dest != 5'd0));
  a_r1_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < (CW+1)'(W)));
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == (CW+1)'(W)));
  a_r2_pair_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !pend_v) |=> ($stable(hi_q) && $stable(lo_q)));
  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);
endmodule

// File: tb/hilo_muldiv_tb_top.sv
module hilo_muldiv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] funct = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [4:0] dest = '0;
  logic busy, done, wr_en;
  logic [4:0] wr_dest;
  logic [31:0] wr_data;
  int checks = 0, fails = 0;
  logic [31:0] m_hi = '0, m_lo = '0;
  bit ended = 0;

  always #2 clk = ~clk;

  hilo_muldiv dut_i (.clk(clk), .rst_n(rst_n), .start(start), .funct(funct),
    .rs_val(rs_val), .rt_val(rt_val), .dest(dest), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_dest(wr_dest), .wr_data(wr_data));

  function automatic logic [63:0] model(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    int ia, ib;
    longint q, r;
    ia = a; ib = b;
    case (f)
      6'h18: begin q = longint'(ia) * longint'(ib); return q; end
      6'h19: return {32'h0, a} * {32'h0, b};
      6'h1a: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        q = longint'(ia) / longint'(ib);
        r = longint'(ia) % longint'(ib);
        return {r[31:0], q[31:0]};
      end
      6'h1b: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        return {a % b, a / b};
      end
      6'h11: return {a, m_lo};
      6'h13: return {m_hi, a};
      default: return {m_hi, m_lo};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [5:0] f, logic [31:0] a, logic [31:0] b, logic [4:0] d);
    @(negedge clk);
    start = 1'b1; funct = f; rs_val = a; rt_val = b; dest = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int nbusy);
    nbusy = 0;
    for (int i = 0; i < 100 && !done; i++) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic op(string tag, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    logic [63:0] e;
    int nb;
    e = model(f, a, b);
    send(f, a, b, 5'd9);
    wait_done(nb);
    check({tag, " done"}, {31'h0, done}, 32'h1);
    check({tag, " no write"}, {31'h0, wr_en}, 32'h0);
    if (f == 6'h1a || f == 6'h1b) check({tag, " busy cycles"}, nb, 32);
    m_hi = e[63:32]; m_lo = e[31:0];
  endtask

  task automatic read(string tag, logic [5:0] f, logic [4:0] d);
    int nb;
    send(f, 32'h0, 32'h0, d);
    wait_done(nb);
    check({tag, " done"}, {31'h0, done}, 32'h1);
    check({tag, " wr_en"}, {31'h0, wr_en}, {31'h0, d != 0});
    if (d != 0) begin
      check({tag, " dest"}, {27'h0, wr_dest}, {27'h0, d});
      check({tag, " data"}, wr_data, f == 6'h10 ? m_hi : m_lo);
    end
  endtask

  task automatic op_chk(string tag, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    op(tag, f, a, b);
    read({tag, " HI"}, 6'h10, 5'd1);
    read({tag, " LO"}, 6'h12, 5'd2);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] fs [6];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset busy", {31'h0, busy}, 0);
    check("reset done", {31'h0, done}, 0);
    check("reset wr_en", {31'h0, wr_en}, 0);
    read("R1 reset HI", 6'h10, 5'd4);

    op("R2 mthi", 6'h11, 32'h1234_5678, 32'h0);
    op("R2 mtlo", 6'h13, 32'hABCD_0001, 32'hFFFF);
    read("R1 mfhi", 6'h10, 5'd5);
    read("R1 mflo", 6'h12, 5'd31);
    read("R5 mfhi dest0", 6'h10, 5'd0);
    read("R5 mflo dest0", 6'h12, 5'd0);

    op_chk("R3 mult neg", 6'h18, 32'hFFFFFFFD, 32'd7);
    op_chk("R3 mult minmin", 6'h18, 32'h80000000, 32'h80000000);
    op_chk("R3 mult m1m1", 6'h18, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op_chk("R4 multu max", 6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op_chk("R4 multu mix", 6'h19, 32'h80000000, 32'd3);

    op_chk("R6 div -7/2", 6'h1a, 32'hFFFFFFF9, 32'd2);
    op_chk("R6 div 7/-2", 6'h1a, 32'd7, 32'hFFFFFFFE);
    op_chk("R6 div -7/-2", 6'h1a, 32'hFFFFFFF9, 32'hFFFFFFFE);
    op_chk("R6 div min/-1", 6'h1a, 32'h80000000, 32'hFFFFFFFF);
    op_chk("R7 divu 100/7", 6'h1b, 32'd100, 32'd7);
    op_chk("R7 divu big", 6'h1b, 32'hFFFFFFFF, 32'h80000000);
    op_chk("R8 div -5/0", 6'h1a, 32'hFFFFFFFB, 32'h0);
    op_chk("R8 divu 123/0", 6'h1b, 32'd123, 32'h0);

    op("R2 mthi pre", 6'h11, 32'h5A5A5A5A, 0);
    op("R2 mtlo pre", 6'h13, 32'hC3C3C3C3, 0);
    op("R10 bad funct", 6'h20, 32'h1111, 32'h2222);
    read("R10 HI kept", 6'h10, 5'd6);
    read("R10 LO kept", 6'h12, 5'd7);

    begin : pend_test
      logic [63:0] e;
      int nb;
      e = model(6'h1b, 32'd1000, 32'd37);
      @(negedge clk);
      start = 1'b1; funct = 6'h1b; rs_val = 32'd1000; rt_val = 32'd37; dest = 5'd0;
      @(negedge clk);
      funct = 6'h10; dest = 5'd3;
      @(negedge clk);
      start = 1'b0;
      wait_done(nb);
      check("R9 divide done", {31'h0, done}, 1);
      check("R9 divide no write", {31'h0, wr_en}, 0);
      @(negedge clk);
      check("R9 held done", {31'h0, done}, 1);
      check("R9 held wr_en", {31'h0, wr_en}, 1);
      check("R9 held dest", {27'h0, wr_dest}, 3);
      check("R9 held data", wr_data, e[63:32]);
      m_hi = e[63:32]; m_lo = e[31:0];
      read("R9 LO after", 6'h12, 5'd8);
    end

    fs = '{6'h18, 6'h19, 6'h1a, 6'h1b, 6'h11, 6'h13};
    for (int i = 0; i < 150; i++) begin
      logic [5:0] f;
      f = fs[$urandom % 6];
      case (f)
        6'h18: op_chk("R3 rand mult", f, pick(), pick());
        6'h19: op_chk("R4 rand multu", f, pick(), pick());
        6'h1a: op_chk("R6 rand div", f, pick(), pick());
        6'h1b: op_chk("R7 rand divu", f, pick(), pick());
        default: op_chk("R2 rand move", f, pick(), pick());
      endcase
    end

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule